// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects up to 32 interrupt sources into one latched status register. Each source is gated by a bit in an enable register. The block drives a single interrupt request line towards a processor. It also presents, through a read-only register, the number of the most urgent source that is both pending and enabled. Of the 32 positions, 6 are driven from asynchronous external pins and 8 from synchronous on-chip peripheral lines. All other positions are unimplemented and read as zero.

Source numbering runs from the most significant bit downwards: source n owns bit 31 − n, and source 0 has the highest priority. A status bit is latched on a rising edge of its source. It stays set until software writes a one to it. Software reads and writes through a plain single-cycle register port. Reads are combinational from the address, and a write takes effect on the clock edge where the write strobe is high. The port has no handshake and no back-pressure: every access completes in the cycle in which it is presented.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the status and enable registers read zero, `irq_o` is low and the vector register reads 32'hFFFF_FFFF.
- R2: Source n occupies register bit 31 − n. External pin `ext_irq_i[k]` is source k (0..5) and internal line `int_irq_i[k]` is source 6 + k (6..13).
- R3: A status bit is set by a rising edge of its source. An external pin passes through two synchroniser flops, so its bit reads set three clock edges after the pin rises. An internal line's bit reads set one edge after the line rises. A source held high does not set its bit again after a clear.
- R4: Writing the status register (address 0) clears every bit written as one. Bits written as zero keep their value.
- R5: When a rising edge and a clearing write hit the same status bit on the same clock edge, the bit ends up set.
- R6: The enable register (address 1) is read/write. Bit positions of unimplemented sources (bits 17..0) always read zero in both the status and the enable register.
- R7: `irq_o` is the OR of (status AND enable), registered, so it follows a change in either register one clock edge later.
- R8: The vector register (address 2) returns the lowest-numbered source that is pending and enabled, as a 6-bit signed number sign-extended to 32 bits.
- R9: With no source pending and enabled, the vector register returns −1 (all ones).
- R10: Writes to address 2 or 3 change no register. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | 6 | Asynchronous external interrupt pins, sources 0..5 |
| int_irq_i | input | 8 | Synchronous peripheral interrupt lines, sources 6..13 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 enable, 2 vector, 3 reserved |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Some properties are checked on every cycle:
- The request line lags the pending-and-enabled OR by exactly one edge.
- A status bit only falls on a status write.
- A detected edge always leaves its bit set.
- Unimplemented positions stay zero.
- The reported vector is always a pending bit with no more urgent pending bit above it, or −1 when nothing is pending.
- Each detected edge lasts one cycle.

Other behaviour can only be shown by the bench's directed scenarios:
- the exact synchroniser latency;
- the mapping of pins onto bit positions;
- that a high level does not re-arm a cleared bit;
- that writes to the vector and reserved addresses are ignored;
- the sign-extended values read back over the register port.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_ENABLE = 2'd1,
    RA_VECTOR = 2'd2,
    RA_RSVD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
  parameter int N     = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] synced;
  logic [N-1:0] prev_q;

  generate
    if (STAGES > 0) begin : g_sync
      logic [N-1:0] chain_q [STAGES];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
          chain_q[0] <= lvl_i;
          for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign synced = chain_q[STAGES-1];
    end else begin : g_direct
      assign synced = lvl_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= synced;
  end

  assign rise_o = synced & ~prev_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & $past(rise_o)) == '0); // R3
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int                     NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0]     IMPL_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               stat_wr_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] stat_q, en_q;
  logic [NUM_SRC-1:0] clr_mask;

  assign clr_mask = stat_wr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= ((stat_q & ~clr_mask) | set_i) & IMPL_MASK;
      if (en_wr_i) en_q <= wdata_i & IMPL_MASK;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;

  AST_STAT_FALL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_i |=> (($past(stat_q) & ~stat_q) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R5
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | en_q) & ~IMPL_MASK) == '0); // R6
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = $clog2(NUM_SRC) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic               any_o
);
  localparam int IDX_W = VEC_W - 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i]) idx = IDX_W'(NUM_SRC - 1 - i);
    end
  end

  assign any_o = |pend_i;
  assign vec_o = any_o ? {1'b0, idx} : '1;

  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> (vec_o == '1)); // R9
  AST_VEC_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i != '0) |-> (!vec_o[VEC_W-1] && pend_i[NUM_SRC-1-int'(vec_o[IDX_W-1:0])])); // R8
  AST_VEC_MOST_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i != '0) |-> ((pend_i >> (NUM_SRC - int'(vec_o[IDX_W-1:0]))) == '0)); // R8
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_EXT = 6,
  parameter int NUM_INT = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic [NUM_INT-1:0] int_irq_i,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  localparam int NUM_IMPL = NUM_EXT + NUM_INT;
  localparam int VEC_W    = $clog2(NUM_SRC) + 1;
  localparam logic [NUM_SRC-1:0] IMPL_MASK = ~({NUM_SRC{1'b1}} >> NUM_IMPL);

  logic [NUM_EXT-1:0] ext_rise;
  logic [NUM_INT-1:0] int_rise;
  logic [NUM_SRC-1:0] set_bits, stat, en, pend;
  logic [VEC_W-1:0]   vec;
  logic               any_pend;
  logic               irq_q;
  logic               stat_wr, en_wr;
  reg_addr_e          addr;

  assign addr = reg_addr_e'(reg_addr_i);

  irq_edge_cap #(.N(NUM_EXT), .STAGES(SYNC_STAGES)) u_ext_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(ext_irq_i), .rise_o(ext_rise));

  irq_edge_cap #(.N(NUM_INT), .STAGES(0)) u_int_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(int_irq_i), .rise_o(int_rise));

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
      if (s < NUM_EXT) begin : g_ext
        assign set_bits[NUM_SRC-1-s] = ext_rise[s];
      end else if (s < NUM_IMPL) begin : g_int
        assign set_bits[NUM_SRC-1-s] = int_rise[s-NUM_EXT];
      end else begin : g_none
        assign set_bits[NUM_SRC-1-s] = 1'b0;
      end
    end
  endgenerate

  assign stat_wr = reg_wr_i && (addr == RA_STATUS);
  assign en_wr   = reg_wr_i && (addr == RA_ENABLE);

  irq_status_reg #(.NUM_SRC(NUM_SRC), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_i(set_bits),
    .stat_wr_i(stat_wr), .en_wr_i(en_wr), .wdata_i(reg_wdata_i[NUM_SRC-1:0]),
    .stat_o(stat), .en_o(en));

  assign pend = stat & en;

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .vec_o(vec), .any_o(any_pend));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pend;
  end
  assign irq_o = irq_q;

  always_comb begin
    unique case (addr)
      RA_STATUS: reg_rdata_o = DATA_W'(stat);
      RA_ENABLE: reg_rdata_o = DATA_W'(en);
      RA_VECTOR: reg_rdata_o = {{(DATA_W-VEC_W){vec[VEC_W-1]}}, vec};
      default:   reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(stat & en))); // R7
  AST_IRQ_ZERO_AT_RESET_EXIT: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq_o); // R1
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ext_irq = '0;
  logic [7:0]  int_irq = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .int_irq_i(int_irq),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  always #10 clk = ~clk;

  function automatic logic [31:0] bm(int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wrr(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 status", d, 32'h0);
    rd(2'd1, d); chk("R1 enable", d, 32'h0);
    rd(2'd2, d); chk("R1 vector", d, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ext_edge();
    logic [31:0] d;
    ext_irq[1] = 1'b1;
    cyc(2);
    rd(2'd0, d); chk("R3 ext not before sync", d, 32'h0);
    cyc(1);
    rd(2'd0, d); chk("R2 R3 ext source 1 set", d, bm(1));
    wrr(2'd0, bm(1));
    cyc(4);
    rd(2'd0, d); chk("R3 held level no re-set", d, 32'h0);
    ext_irq[1] = 1'b0;
    cyc(3);
  endtask

  task automatic t_int_edge();
    logic [31:0] d;
    int_irq[2] = 1'b1;
    cyc(1);
    rd(2'd0, d); chk("R2 R3 int source 8 set", d, bm(8));
    int_irq[2] = 1'b0;
    wrr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R4 clear all", d, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    ext_irq[4] = 1'b1; int_irq[5] = 1'b1;
    cyc(4);
    ext_irq[4] = 1'b0; int_irq[5] = 1'b0;
    rd(2'd0, d); chk("R2 two sources", d, bm(4) | bm(11));
    wrr(2'd0, 32'h0);
    rd(2'd0, d); chk("R4 zeros keep", d, bm(4) | bm(11));
    wrr(2'd0, bm(11));
    rd(2'd0, d); chk("R4 clear one", d, bm(4));
    wrr(2'd0, bm(4));
    cyc(2);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    int_irq[3] = 1'b1;
    cyc(1);
    int_irq[3] = 1'b0;
    cyc(2);
    addr = 2'd0; wdata = bm(9); wr = 1'b1; int_irq[3] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    rd(2'd0, d); chk("R5 set beats clear", d, bm(9));
    int_irq[3] = 1'b0;
    wrr(2'd0, bm(9));
    rd(2'd0, d); chk("R4 cleared after", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wrr(2'd1, 32'hA5A5_0000);
    rd(2'd1, d); chk("R6 enable pattern", d, 32'hA5A4_0000);
    wrr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R6 unimpl zero", d, 32'hFFFC_0000);
    wrr(2'd1, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    ext_irq[3] = 1'b1; int_irq[1] = 1'b1; int_irq[6] = 1'b1;
    cyc(4);
    ext_irq[3] = 1'b0; int_irq[1] = 1'b0; int_irq[6] = 1'b0;
    rd(2'd2, d); chk("R9 pending but masked", d, 32'hFFFF_FFFF);
    wrr(2'd1, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R8 source 3 first", d, 32'd3);
    wrr(2'd1, ~bm(3));
    rd(2'd2, d); chk("R8 source 7 when 3 masked", d, 32'd7);
    wrr(2'd0, bm(7));
    rd(2'd2, d); chk("R8 source 12 last", d, 32'd12);
    wrr(2'd0, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R9 none", d, 32'hFFFF_FFFF);
    wrr(2'd1, 32'h0);
    cyc(2);
  endtask

  task automatic t_irq_latency();
    int_irq[0] = 1'b1;
    cyc(2);
    int_irq[0] = 1'b0;
    chk("R7 masked no irq", {31'b0, irq}, 32'h0);
    wrr(2'd1, bm(6));
    chk("R7 irq one edge late", {31'b0, irq}, 32'h0);
    cyc(1);
    chk("R7 irq asserted", {31'b0, irq}, 32'h1);
    wrr(2'd0, bm(6));
    chk("R7 irq still high", {31'b0, irq}, 32'h1);
    cyc(1);
    chk("R7 irq dropped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_vec_write();
    logic [31:0] d;
    int_irq[4] = 1'b1;
    cyc(1);
    int_irq[4] = 1'b0;
    wrr(2'd1, bm(10));
    wrr(2'd2, 32'hFFFF_FFFF);
    wrr(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R10 status unchanged", d, bm(10));
    rd(2'd1, d); chk("R10 enable unchanged", d, bm(10));
    rd(2'd2, d); chk("R10 vector", d, 32'd10);
    rd(2'd3, d); chk("R10 reserved zero", d, 32'h0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_ext_edge();
    t_int_edge();
    t_w1c();
    t_set_wins();
    t_enable();
    t_priority();
    t_irq_latency();
    t_vec_write();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule